// File: doc/BRIEF.md
# Stack and Branch Bus Sequencer

This unit performs the multi-byte memory work of an 8-bit processor with a 16-bit address space. It owns the program counter, the stack pointer and an internal address latch, and it runs one command at a time. A command might be a stack push or pop, a 16-bit word read or write through the latch, a restart, a conditional call, jump or return, or a relative jump. Each byte moves over a byte-wide synchronous bus, one transfer per cycle, with a single-cycle read or write strobe. Read data is returned in the same cycle as the address.

A command is accepted only while the unit is idle, together with its condition bit. `done_o` marks the first idle cycle after the command has finished. For conditional commands, `taken_o` is asserted together with `done_o` when the transfer of control happened. Every transfer of control passes through the address latch, so the latch always holds the most recent branch target or word-access pointer.

Top module: `stk_br_seq`

## Requirements
- R1: After reset, PC is 0x0100, SP is 0x8000, the latch is 0x0000, and `done_o`, `taken_o`, `busy_o` and both strobes are low.
- R2: Command 0 (push) first decrements SP and then writes `byte_i` at the new SP in one write cycle.
- R3: Command 1 (pop) reads the byte at SP in one read cycle, presents it on `pop_data_o` and then increments SP.
- R4: Command 2 (word read) reads the low byte at the latch address and the high byte at that address plus one, in that order. The latch advances by exactly one. `word_o` becomes {high, low}.
- R5: Command 3 (word write) writes `word_i[7:0]` at the latch address, then `word_i[15:8]` at that address plus one. The latch advances by exactly one.
- R6: Command 4 (restart) sets the latch to {0x00, `byte_i`}. It then writes PC[15:8] at SP-1 and PC[7:0] at SP-2, and loads PC with the latch.
- R7: Command 5 (call) always reads a little-endian operand at PC and PC+1, places it in the latch and advances PC by two. Only when `cond_i` is 1 does it push the advanced PC (high byte first, at the higher address) and jump to the operand.
- R8: Command 6 (jump) always reads the two operand bytes and loads the latch with them. PC becomes the operand when `cond_i` is 1 and PC+2 otherwise.
- R9: Command 7 (return) with `cond_i` 1 pops the low byte at SP and the high byte at SP+1, adds two to SP, and loads both PC and the latch with the result. With `cond_i` 0 it makes no bus access and changes nothing.
- R10: Command 8 (relative jump) reads a signed offset at PC. When taken, PC and the latch become PC+1 plus the sign-extended offset. Otherwise PC becomes PC+1 and the latch keeps its value.
- R11: `taken_o` equals the condition bit in the `done_o` cycle of commands 5 to 8, and is low at all other times.
- R12: At most one strobe is active in any cycle. The bus transfers of a command occur in consecutive cycles starting the cycle after acceptance, and `done_o` follows the last of them. A command offered while busy is ignored.
- R13: Command 9 (latch load) copies `word_i` into the latch with no bus access, and `done_o` follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered this cycle |
| cmd_i | input | 4 | Command code |
| cond_i | input | 1 | Condition for commands 5 to 8 |
| byte_i | input | 8 | Push byte or restart vector |
| word_i | input | 16 | Word to write or latch value to load |
| bus_addr_o | output | 16 | Bus address |
| bus_wdata_o | output | 8 | Bus write data |
| bus_rdata_i | input | 8 | Bus read data, valid in the same cycle |
| bus_rd_o | output | 1 | Read strobe |
| bus_wr_o | output | 1 | Write strobe |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished |
| taken_o | output | 1 | Conditional transfer taken |
| pop_data_o | output | 8 | Last popped byte |
| word_o | output | 16 | Last word read |
| pc_o | output | 16 | Program counter |
| sp_o | output | 16 | Stack pointer |
| latch_o | output | 16 | Internal address latch |

## Verification
A command accepted at a clock edge shows its first bus transfer in the cycle that follows, its k-th transfer k cycles after acceptance, and `done_o` with the updated registers one cycle after the last transfer. A command with no transfer raises `done_o` in the very next cycle. The bench builds the expected transfer list for each command before issuing it. It then compares strobes, address and write data at every falling edge, popping one entry per cycle, and checks PC, SP, latch, `taken_o` and the result bytes in the falling edge where the list has run empty. In some runs a second command is held on the input while the unit is busy, which shows that it is ignored.

// File: rtl/stk_br_pkg.sv
package stk_br_pkg;

  typedef enum logic [3:0] {
    CMD_PUSH = 4'd0,
    CMD_POP  = 4'd1,
    CMD_WRD  = 4'd2,
    CMD_WWR  = 4'd3,
    CMD_RST  = 4'd4,
    CMD_CALL = 4'd5,
    CMD_JP   = 4'd6,
    CMD_RET  = 4'd7,
    CMD_JR   = 4'd8,
    CMD_LDL  = 4'd9
  } cmd_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH1,
    ST_POP1,
    ST_WLO,
    ST_WHI,
    ST_FLO,
    ST_FHI,
    ST_PSH_HI,
    ST_PSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_JR
  } st_e;

  function automatic logic is_cond(cmd_e c);
    return (c == CMD_CALL) || (c == CMD_JP) || (c == CMD_RET) || (c == CMD_JR);
  endfunction

endpackage

// File: rtl/stk_br_fsm.sv
module stk_br_fsm
  import stk_br_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_valid_i,
  input  logic [3:0] cmd_i,
  input  logic       cond_i,
  output st_e        state_o,
  output cmd_e       cmd_q_o,
  output cmd_e       cmd_in_o,
  output logic       cond_q_o,
  output logic       accept_o,
  output logic       fin_o,
  output logic       taken_set_o
);

  st_e  st_q, st_d;
  cmd_e cmd_q, cmd_in, fin_cmd;
  logic cond_q, fin_cond, accept;

  assign cmd_in = cmd_e'(cmd_i);
  assign accept = cmd_valid_i && (st_q == ST_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (accept) begin
        case (cmd_in)
          CMD_PUSH:         st_d = ST_PUSH1;
          CMD_POP:          st_d = ST_POP1;
          CMD_WRD, CMD_WWR: st_d = ST_WLO;
          CMD_RST:          st_d = ST_PSH_HI;
          CMD_CALL, CMD_JP: st_d = ST_FLO;
          CMD_JR:           st_d = ST_JR;
          CMD_RET:          st_d = cond_i ? ST_POP_LO : ST_IDLE;
          default:          st_d = ST_IDLE;
        endcase
      end
      ST_WLO:    st_d = ST_WHI;
      ST_FLO:    st_d = ST_FHI;
      ST_FHI:    st_d = (cmd_q == CMD_CALL && cond_q) ? ST_PSH_HI : ST_IDLE;
      ST_PSH_HI: st_d = ST_PSH_LO;
      ST_POP_LO: st_d = ST_POP_HI;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cmd_q  <= CMD_PUSH;
      cond_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        cmd_q  <= cmd_in;
        cond_q <= cond_i;
      end
    end
  end

  // zero-transfer commands finish straight from idle
  assign fin_cmd  = (st_q == ST_IDLE) ? cmd_in : cmd_q;
  assign fin_cond = (st_q == ST_IDLE) ? cond_i : cond_q;
  assign fin_o       = (st_d == ST_IDLE) && ((st_q != ST_IDLE) || accept);
  assign taken_set_o = fin_o && is_cond(fin_cmd) && fin_cond;

  assign state_o  = st_q;
  assign cmd_q_o  = cmd_q;
  assign cmd_in_o = cmd_in;
  assign cond_q_o = cond_q;
  assign accept_o = accept;

  AST_RET_SKIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && cmd_in == CMD_RET && !cond_i |=> st_q == ST_IDLE); // R9
  AST_BUSY_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != ST_IDLE |=> $stable(cmd_q) && $stable(cond_q)); // R12

endmodule

// File: rtl/stk_br_dp.sv
module stk_br_dp
  import stk_br_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [2*DATA_W-1:0] PC_RST = 16'h0100,
  parameter logic [2*DATA_W-1:0] SP_RST = 16'h8000,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  st_e               state_i,
  input  cmd_e              cmd_i,
  input  logic              cond_i,
  input  logic              accept_i,
  input  cmd_e              acc_cmd_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] word_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] lat_o,
  output logic [DATA_W-1:0] pop_o,
  output logic [ADDR_W-1:0] word_o
);

  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] pc_q, sp_q, lat_q, addr_q, wword_q, word_q, jr_tgt, addr_c;
  logic [DATA_W-1:0] data_q, tmp_lo, pop_q, wdata_c;
  logic              rd_c, wr_c;

  assign jr_tgt = pc_q + ONE + {{DATA_W{rdata_i[DATA_W-1]}}, rdata_i};

  always_comb begin
    rd_c    = 1'b0;
    wr_c    = 1'b0;
    addr_c  = pc_q;
    wdata_c = '0;
    case (state_i)
      ST_PUSH1: begin
        wr_c = 1'b1; addr_c = sp_q - ONE; wdata_c = data_q;
      end
      ST_POP1, ST_POP_LO, ST_POP_HI: begin
        rd_c = 1'b1; addr_c = sp_q;
      end
      ST_WLO: begin
        rd_c = (cmd_i == CMD_WRD); wr_c = (cmd_i == CMD_WWR);
        addr_c = lat_q; wdata_c = wword_q[DATA_W-1:0];
      end
      ST_WHI: begin
        rd_c = (cmd_i == CMD_WRD); wr_c = (cmd_i == CMD_WWR);
        addr_c = addr_q + ONE; wdata_c = wword_q[ADDR_W-1:DATA_W];
      end
      ST_FLO, ST_FHI, ST_JR: begin
        rd_c = 1'b1; addr_c = pc_q;
      end
      ST_PSH_HI: begin
        wr_c = 1'b1; addr_c = sp_q - ONE; wdata_c = pc_q[ADDR_W-1:DATA_W];
      end
      ST_PSH_LO: begin
        wr_c = 1'b1; addr_c = sp_q - ONE; wdata_c = pc_q[DATA_W-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= PC_RST;
      sp_q    <= SP_RST;
      lat_q   <= '0;
      addr_q  <= '0;
      wword_q <= '0;
      word_q  <= '0;
      data_q  <= '0;
      tmp_lo  <= '0;
      pop_q   <= '0;
    end else begin
      if (accept_i) begin
        data_q  <= byte_i;
        wword_q <= word_i;
        if (acc_cmd_i == CMD_RST) lat_q <= {{DATA_W{1'b0}}, byte_i};
        if (acc_cmd_i == CMD_LDL) lat_q <= word_i;
      end
      case (state_i)
        ST_PUSH1: sp_q <= sp_q - ONE;
        ST_POP1: begin
          pop_q <= rdata_i;
          sp_q  <= sp_q + ONE;
        end
        ST_WLO: begin
          addr_q <= lat_q;
          lat_q  <= lat_q + ONE;
          tmp_lo <= rdata_i;
        end
        ST_WHI: if (cmd_i == CMD_WRD) word_q <= {rdata_i, tmp_lo};
        ST_FLO: begin
          tmp_lo <= rdata_i;
          pc_q   <= pc_q + ONE;
        end
        ST_FHI: begin
          lat_q <= {rdata_i, tmp_lo};
          pc_q  <= (cmd_i == CMD_JP && cond_i) ? {rdata_i, tmp_lo} : pc_q + ONE;
        end
        ST_PSH_HI: sp_q <= sp_q - ONE;
        ST_PSH_LO: begin
          sp_q <= sp_q - ONE;
          pc_q <= lat_q;
        end
        ST_POP_LO: begin
          tmp_lo <= rdata_i;
          sp_q   <= sp_q + ONE;
        end
        ST_POP_HI: begin
          sp_q  <= sp_q + ONE;
          pc_q  <= {rdata_i, tmp_lo};
          lat_q <= {rdata_i, tmp_lo};
        end
        ST_JR: begin
          pc_q <= cond_i ? jr_tgt : pc_q + ONE;
          if (cond_i) lat_q <= jr_tgt;
        end
        default: ;
      endcase
    end
  end

  assign addr_o  = addr_c;
  assign wdata_o = wdata_c;
  assign rd_o    = rd_c;
  assign wr_o    = wr_c;
  assign pc_o    = pc_q;
  assign sp_o    = sp_q;
  assign lat_o   = lat_q;
  assign pop_o   = pop_q;
  assign word_o  = word_q;

  AST_PUSH_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_PUSH1 |=> sp_q == $past(addr_c)); // R2
  AST_POP_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_POP1 |=> sp_q == $past(addr_c) + ONE); // R3
  AST_WHI_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_WHI |-> addr_c == lat_q); // R4
  AST_JP_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_FHI && cmd_i == CMD_JP && cond_i |=> pc_q == lat_q); // R8
  AST_RST_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_PSH_HI && cmd_i == CMD_RST |-> lat_q[ADDR_W-1:DATA_W] == '0); // R6
  AST_RET_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_POP_HI |=> pc_q == lat_q); // R9

endmodule

// File: rtl/stk_br_seq.sv
module stk_br_seq
  import stk_br_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [2*DATA_W-1:0] PC_RST = 16'h0100,
  parameter logic [2*DATA_W-1:0] SP_RST = 16'h8000,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [3:0]        cmd_i,
  input  logic              cond_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic [ADDR_W-1:0] word_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              taken_o,
  output logic [DATA_W-1:0] pop_data_o,
  output logic [ADDR_W-1:0] word_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic [ADDR_W-1:0] latch_o
);

  st_e  state;
  cmd_e cmd_q, cmd_in;
  logic cond_q, accept, fin, taken_set, done_q, taken_q;

  stk_br_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cmd_valid_i (cmd_valid_i),
    .cmd_i       (cmd_i),
    .cond_i      (cond_i),
    .state_o     (state),
    .cmd_q_o     (cmd_q),
    .cmd_in_o    (cmd_in),
    .cond_q_o    (cond_q),
    .accept_o    (accept),
    .fin_o       (fin),
    .taken_set_o (taken_set)
  );

  stk_br_dp #(
    .DATA_W (DATA_W),
    .PC_RST (PC_RST),
    .SP_RST (SP_RST)
  ) u_dp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .state_i   (state),
    .cmd_i     (cmd_q),
    .cond_i    (cond_q),
    .accept_i  (accept),
    .acc_cmd_i (cmd_in),
    .byte_i    (byte_i),
    .word_i    (word_i),
    .rdata_i   (bus_rdata_i),
    .addr_o    (bus_addr_o),
    .wdata_o   (bus_wdata_o),
    .rd_o      (bus_rd_o),
    .wr_o      (bus_wr_o),
    .pc_o      (pc_o),
    .sp_o      (sp_o),
    .lat_o     (latch_o),
    .pop_o     (pop_data_o),
    .word_o    (word_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      done_q  <= fin;
      taken_q <= taken_set;
    end
  end

  assign done_o  = done_q;
  assign taken_o = taken_q;
  assign busy_o  = (state != ST_IDLE);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o)); // R12
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !bus_rd_o && !bus_wr_o); // R12
  AST_TAKEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_o |-> done_o); // R11

endmodule

// File: tb/stk_br_seq_tb.sv
module stk_br_seq_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd = '0;
  logic        cond = 1'b0;
  logic [7:0]  byte_v = '0;
  logic [15:0] word_v = '0;
  logic [15:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata = '0;
  logic        bus_rd, bus_wr, busy, done, taken;
  logic [7:0]  pop_data;
  logic [15:0] word_o, pc, sp, lat;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  stk_br_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .cond_i(cond),
    .byte_i(byte_v), .word_i(word_v), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata), .bus_rd_o(bus_rd), .bus_wr_o(bus_wr), .busy_o(busy),
    .done_o(done), .taken_o(taken), .pop_data_o(pop_data), .word_o(word_o),
    .pc_o(pc), .sp_o(sp), .latch_o(lat)
  );

  // memory seen by the design, and the model's own copy
  logic [7:0] mem [logic [15:0]];
  logic [7:0] ref_mem [logic [15:0]];

  function automatic logic [7:0] rd_mem(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rd_ref(input logic [15:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) if (rst_n && bus_wr) mem[bus_addr] = bus_wdata;
  always @(negedge clk) bus_rdata = rd_mem(bus_addr);

  typedef struct packed { logic wr; logic [15:0] a; logic [7:0] d; } op_t;
  op_t q[$];

  logic [15:0] m_pc = 16'h0100, m_sp = 16'h8000, m_lat = 16'h0000;
  logic [7:0]  m_pop;
  logic [15:0] m_word;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic m_push(input logic [7:0] d);
    m_sp = m_sp - 16'd1;
    q.push_back('{1'b1, m_sp, d});
    ref_mem[m_sp] = d;
  endtask

  task automatic run(input logic [3:0] c, input bit cd, input logic [7:0] b,
                     input logic [15:0] w, input bit poke, input string req);
    logic [15:0] t;
    logic [7:0]  lo, hi;
    bit          is_c;
    is_c = (c >= 4'd5 && c <= 4'd8);
    case (c)
      4'd0: m_push(b);
      4'd1: begin
        q.push_back('{1'b0, m_sp, 8'h00}); m_pop = rd_ref(m_sp); m_sp = m_sp + 16'd1;
      end
      4'd2, 4'd3: begin
        t = m_lat; m_lat = m_lat + 16'd1;
        if (c == 4'd2) begin
          lo = rd_ref(t); hi = rd_ref(t + 16'd1); m_word = {hi, lo};
          q.push_back('{1'b0, t, 8'h00}); q.push_back('{1'b0, t + 16'd1, 8'h00});
        end else begin
          q.push_back('{1'b1, t, w[7:0]}); q.push_back('{1'b1, t + 16'd1, w[15:8]});
          ref_mem[t] = w[7:0]; ref_mem[t + 16'd1] = w[15:8];
        end
      end
      4'd4: begin
        m_lat = {8'h00, b}; m_push(m_pc[15:8]); m_push(m_pc[7:0]); m_pc = m_lat;
      end
      4'd5, 4'd6: begin
        lo = rd_ref(m_pc); hi = rd_ref(m_pc + 16'd1);
        q.push_back('{1'b0, m_pc, 8'h00}); q.push_back('{1'b0, m_pc + 16'd1, 8'h00});
        m_pc = m_pc + 16'd2; m_lat = {hi, lo};
        if (cd) begin
          if (c == 4'd5) begin m_push(m_pc[15:8]); m_push(m_pc[7:0]); end
          m_pc = m_lat;
        end
      end
      4'd7: if (cd) begin
        lo = rd_ref(m_sp); hi = rd_ref(m_sp + 16'd1);
        q.push_back('{1'b0, m_sp, 8'h00}); q.push_back('{1'b0, m_sp + 16'd1, 8'h00});
        m_sp = m_sp + 16'd2; m_pc = {hi, lo}; m_lat = m_pc;
      end
      4'd8: begin
        lo = rd_ref(m_pc); q.push_back('{1'b0, m_pc, 8'h00});
        m_pc = m_pc + 16'd1;
        if (cd) begin m_pc = m_pc + {{8{lo[7]}}, lo}; m_lat = m_pc; end
      end
      4'd9: m_lat = w;
      default: ;
    endcase
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; cond = cd; byte_v = b; word_v = w;
    @(posedge clk);
    @(negedge clk);
    if (poke) begin cmd = 4'd0; cond = 1'b1; byte_v = 8'hEE; end
    else cmd_valid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (q.size() > 0) begin
        op_t e;
        e = q.pop_front();
        chk(req, "bus op {rd,wr,addr,wdata}",
            {5'd0, bus_rd, bus_wr, bus_addr, bus_wr ? bus_wdata : 8'h00},
            {5'd0, ~e.wr, e.wr, e.a, e.wr ? e.d : 8'h00});
        chk("R12", "done during transfers", {31'd0, done}, 32'd0);
      end else begin
        cmd_valid = 1'b0;
        chk("R12", "done after last transfer", {30'd0, done, bus_rd | bus_wr}, 32'd2);
        chk(req, "pc", {16'd0, pc}, {16'd0, m_pc});
        chk(req, "sp", {16'd0, sp}, {16'd0, m_sp});
        chk(req, "latch", {16'd0, lat}, {16'd0, m_lat});
        chk("R11", "taken", {31'd0, taken}, {31'd0, is_c && cd});
        if (c == 4'd1) chk(req, "pop data", {24'd0, pop_data}, {24'd0, m_pop});
        if (c == 4'd2) chk(req, "word", {16'd0, word_o}, {16'd0, m_word});
        if (poke) chk("R12", "busy offer ignored sp", {16'd0, sp}, {16'd0, m_sp});
        break;
      end
      @(negedge clk);
    end
    if (q.size() > 0) begin
      chk(req, "transfers missing", q.size(), 0);
      q.delete();
    end
  endtask

  initial begin
    for (int a = 16'h0100; a < 16'h0200; a++) begin
      mem[16'(a)] = 8'((a * 7 + 3) & 8'hff);
      ref_mem[16'(a)] = 8'((a * 7 + 3) & 8'hff);
    end
    for (int a = 16'h1200; a < 16'h1300; a++) begin
      mem[16'(a)] = 8'((a * 5 + 1) & 8'hff);
      ref_mem[16'(a)] = 8'((a * 5 + 1) & 8'hff);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "pc", {16'd0, pc}, 32'h0100);
    chk("R1", "sp", {16'd0, sp}, 32'h8000);
    chk("R1", "latch", {16'd0, lat}, 32'h0000);
    chk("R1", "outputs {done,taken,busy,rd,wr}", {27'd0, done, taken, busy, bus_rd, bus_wr}, 32'd0);

    run(4'd0, 1'b0, 8'hA5, 16'h0, 1'b0, "R2");
    run(4'd0, 1'b0, 8'h5A, 16'h0, 1'b0, "R2");
    run(4'd1, 1'b0, 8'h00, 16'h0, 1'b1, "R3");
    run(4'd1, 1'b0, 8'h00, 16'h0, 1'b0, "R3");
    run(4'd9, 1'b0, 8'h00, 16'h2000, 1'b0, "R13");
    run(4'd3, 1'b0, 8'h00, 16'hBEEF, 1'b1, "R5");
    run(4'd9, 1'b0, 8'h00, 16'h2000, 1'b0, "R13");
    run(4'd2, 1'b0, 8'h00, 16'h0, 1'b0, "R4");
    run(4'd2, 1'b0, 8'h00, 16'h0, 1'b0, "R4");
    run(4'd6, 1'b0, 8'h00, 16'h0, 1'b0, "R8");
    run(4'd5, 1'b0, 8'h00, 16'h0, 1'b0, "R7");
    run(4'd5, 1'b1, 8'h00, 16'h0, 1'b1, "R7");
    run(4'd7, 1'b0, 8'h00, 16'h0, 1'b0, "R9");
    run(4'd7, 1'b1, 8'h00, 16'h0, 1'b0, "R9");
    run(4'd8, 1'b0, 8'h00, 16'h0, 1'b0, "R10");
    mem[m_pc] = 8'hFE; ref_mem[m_pc] = 8'hFE;
    run(4'd8, 1'b1, 8'h00, 16'h0, 1'b0, "R10");
    mem[m_pc] = 8'h7F; ref_mem[m_pc] = 8'h7F;
    run(4'd8, 1'b1, 8'h00, 16'h0, 1'b1, "R10");
    run(4'd4, 1'b0, 8'h38, 16'h0, 1'b0, "R6");
    run(4'd7, 1'b1, 8'h00, 16'h0, 1'b0, "R9");
    run(4'd9, 1'b0, 8'h00, 16'h0100, 1'b0, "R13");
    run(4'd6, 1'b1, 8'h00, 16'h0, 1'b1, "R8");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule